// File: doc/BRIEF.md
# Linked-Descriptor Transmit Walker

This block is the transmit engine of a scatter-gather DMA channel. It follows a chain of buffer descriptors held in memory, reached through a simple word-wide memory port with a request/acknowledge handshake. For each descriptor it reads the link, buffer and control fields, then checks whether the descriptor is already marked as done. If the descriptor starts a frame, it forwards the five per-frame application words on a side control stream. It then sends the buffer bytes on a 32-bit data stream with byte keep and a last flag, writes a completion status back into the descriptor, and moves on to the next link.

The walk ends in one of two ways. If it fetches a descriptor that is already marked done, the channel halts. After it handles the descriptor at the tail address, the channel goes idle. Writing a new tail address clears idle and resumes the walk from the saved pointer. A rising edge on the run input clears both halt and idle. A frame may cover several descriptors: the first carries a start-of-frame mark, the last an end-of-frame mark, and one completion pulse is emitted per frame.

Top module: `sgw_walker`

## Requirements
- R1: After reset, halted_o is 1, idle_o is 0, done_o is 0, and there is no memory request and no valid beat on either stream.
- R2: A walk starts only while run_i is 1 and neither halted_o nor idle_o is set. A rising edge of run_i clears both flags. A tail write while halted does not start a walk.
- R3: Descriptor fields are read as 32-bit little-endian words at byte offsets from the descriptor base: link at 0x00, buffer address at 0x08, control at 0x18, status at 0x1C. Only the low words of the 64-bit fields are used.
- R4: In the control word, bit 27 marks start of frame, bit 26 marks end of frame, and bits 22:0 give the buffer length in bytes.
- R5: If status bit 31 of a fetched descriptor is already 1, halted_o rises. No beat is sent, nothing is written back, and the walk stops.
- R6: On a start-of-frame descriptor, the five words at offsets 0x20, 0x24, 0x28, 0x2C and 0x30 go out in that order on the control stream before any data beat. The control last flag is set on the fifth word.
- R7: Buffer words are sent in address order. Byte lane k is bits 8k+7:8k. Every beat has keep 1111 except the final beat of a descriptor, which keeps the low (length mod 4) lanes, or all four when the length is a multiple of 4.
- R8: Data last is set only on the final beat of an end-of-frame descriptor.
- R9: After the data, the status word at 0x1C is written with the value length | 0x80000000.
- R10: For each end-of-frame descriptor, done_o is high for exactly one cycle: the cycle after the status write is acknowledged.
- R11: After the descriptor whose base equals the tail address is written back, idle_o rises in the cycle after the write acknowledge, and the walk stops. A later tail write resumes the walk at that descriptor's link.
- R12: While a data beat waits for ready, its data and keep stay stable, and no memory request is made.
- R13: A descriptor of length 0 sends no data beat but is still written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Channel run enable (level) |
| cur_wr_i | input | 1 | Load current descriptor pointer (accepted while waiting) |
| cur_addr_i | input | AW | Current descriptor pointer value |
| tail_wr_i | input | 1 | Load tail pointer; clears idle |
| tail_addr_i | input | AW | Tail descriptor address |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | AW | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| ctl_tvalid_o | output | 1 | Control stream valid |
| ctl_tready_i | input | 1 | Control stream ready |
| ctl_tdata_o | output | 32 | Control stream application word |
| ctl_tlast_o | output | 1 | Control stream last word |
| dat_tvalid_o | output | 1 | Data stream valid |
| dat_tready_i | input | 1 | Data stream ready |
| dat_tdata_o | output | 32 | Data stream word |
| dat_tkeep_o | output | 4 | Data stream byte keep |
| dat_tlast_o | output | 1 | Data stream end of frame |
| halted_o | output | 1 | Channel halted |
| idle_o | output | 1 | Channel reached the tail |
| done_o | output | 1 | One-cycle frame completion pulse |

## Verification
The bench memory answers every request one cycle later with a registered acknowledge. idle_o, halted_o and done_o are registered, so each is due exactly one cycle after the acknowledge edge that causes it. The bench records the cycle of every status-write acknowledge and every done and idle rise, then checks that the gap is exactly one. Stream beats are captured at the falling edge whenever valid and ready are both high, which is the beat the next rising edge accepts. The stall check compares each stalled beat with the one before it, half a cycle away from any edge.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int WORD_W    = 32;
    localparam int OFS_LINK  = 'h00;
    localparam int OFS_BUF   = 'h08;
    localparam int OFS_CTRL  = 'h18;
    localparam int OFS_STAT  = 'h1C;
    localparam int OFS_APP   = 'h20;
    localparam int BIT_SOF   = 27;
    localparam int BIT_EOF   = 26;
    localparam int BIT_DONE  = 31;

    typedef enum logic [3:0] {
        ST_WAIT,
        ST_RD_LINK,
        ST_RD_BUF,
        ST_RD_CTRL,
        ST_RD_STAT,
        ST_RD_APP,
        ST_SEND_APP,
        ST_RD_DATA,
        ST_SEND_DATA,
        ST_WR_STAT
    } walk_state_e;
endpackage

// File: rtl/sgw_keep_calc.sv
module sgw_keep_calc #(
    parameter int LEN_W  = 23,
    parameter int KEEP_W = 4
) (
    input  logic [LEN_W-1:0]  left_i,
    output logic [KEEP_W-1:0] keep_o,
    output logic              final_o
);
    assign final_o = (left_i <= LEN_W'(KEEP_W));

    for (genvar g = 0; g < KEEP_W; g++) begin : g_lane
        assign keep_o[g] = !final_o || (left_i > LEN_W'(g));
    end
endmodule

// File: rtl/sgw_chan_flags.sv
module sgw_chan_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tail_wr_i,
    input  logic set_halt_i,
    input  logic set_idle_i,
    output logic halted_o,
    output logic idle_o
);
    logic run_q, halted_q, idle_q;
    logic halted_d, idle_d;
    logic run_rise;

    assign run_rise = run_i && !run_q;

    always_comb begin
        halted_d = halted_q;
        idle_d   = idle_q;
        if (run_rise) begin
            halted_d = 1'b0;
            idle_d   = 1'b0;
        end
        if (tail_wr_i) idle_d = 1'b0;
        if (set_halt_i) halted_d = 1'b1;
        if (set_idle_i) idle_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            halted_q <= 1'b1;
            idle_q   <= 1'b0;
        end else begin
            run_q    <= run_i;
            halted_q <= halted_d;
            idle_q   <= idle_d;
        end
    end

    assign halted_o = halted_q;
    assign idle_o   = idle_q;

    AST_HALT_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        set_halt_i |=> halted_o); // R5
    AST_IDLE_ON_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        set_idle_i |=> idle_o); // R11
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
    import sgw_pkg::*;
#(
    parameter int AW        = 32,
    parameter int LEN_W     = 23,
    parameter int APP_WORDS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              cur_wr_i,
    input  logic [AW-1:0]     cur_addr_i,
    input  logic              tail_wr_i,
    input  logic [AW-1:0]     tail_addr_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              ctl_tvalid_o,
    input  logic              ctl_tready_i,
    output logic [WORD_W-1:0] ctl_tdata_o,
    output logic              ctl_tlast_o,
    output logic              dat_tvalid_o,
    input  logic              dat_tready_i,
    output logic [WORD_W-1:0] dat_tdata_o,
    output logic [WORD_W/8-1:0] dat_tkeep_o,
    output logic              dat_tlast_o,
    output logic              halted_o,
    output logic              idle_o,
    output logic              done_o
);
    localparam int KEEP_W = WORD_W / 8;
    localparam int IDX_W  = $clog2(APP_WORDS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(APP_WORDS - 1);

    typedef struct packed {
        walk_state_e       st;
        logic [AW-1:0]     cur;
        logic [AW-1:0]     tail;
        logic [AW-1:0]     link;
        logic [AW-1:0]     bptr;
        logic              sof;
        logic              eof;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  left;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
        logic              done;
    } walk_regs_t;

    walk_regs_t r_d, r_q;
    logic set_halt, set_idle;
    logic [KEEP_W-1:0] keep;
    logic last_beat;

    sgw_keep_calc #(.LEN_W(LEN_W), .KEEP_W(KEEP_W)) u_keep (
        .left_i  (r_q.left),
        .keep_o  (keep),
        .final_o (last_beat)
    );

    sgw_chan_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_i),
        .tail_wr_i  (tail_wr_i),
        .set_halt_i (set_halt),
        .set_idle_i (set_idle),
        .halted_o   (halted_o),
        .idle_o     (idle_o)
    );

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        set_halt     = 1'b0;
        set_idle     = 1'b0;
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = r_q.cur;
        mem_wdata_o  = '0;
        ctl_tvalid_o = 1'b0;
        dat_tvalid_o = 1'b0;
        if (tail_wr_i) r_d.tail = tail_addr_i;

        unique case (r_q.st)
            ST_WAIT: begin
                if (cur_wr_i) r_d.cur = cur_addr_i;
                else if (run_i && !halted_o && !idle_o) r_d.st = ST_RD_LINK;
            end
            ST_RD_LINK: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.cur + AW'(OFS_LINK);
                if (mem_ack_i) begin
                    r_d.link = mem_rdata_i[AW-1:0];
                    r_d.st   = ST_RD_BUF;
                end
            end
            ST_RD_BUF: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.cur + AW'(OFS_BUF);
                if (mem_ack_i) begin
                    r_d.bptr = mem_rdata_i[AW-1:0];
                    r_d.st   = ST_RD_CTRL;
                end
            end
            ST_RD_CTRL: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.cur + AW'(OFS_CTRL);
                if (mem_ack_i) begin
                    r_d.sof  = mem_rdata_i[BIT_SOF];
                    r_d.eof  = mem_rdata_i[BIT_EOF];
                    r_d.len  = mem_rdata_i[LEN_W-1:0];
                    r_d.left = mem_rdata_i[LEN_W-1:0];
                    r_d.st   = ST_RD_STAT;
                end
            end
            ST_RD_STAT: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.cur + AW'(OFS_STAT);
                if (mem_ack_i) begin
                    if (mem_rdata_i[BIT_DONE]) begin
                        set_halt = 1'b1;
                        r_d.st   = ST_WAIT;
                    end else if (r_q.sof) begin
                        r_d.idx = '0;
                        r_d.st  = ST_RD_APP;
                    end else if (r_q.left == '0) begin
                        r_d.st = ST_WR_STAT;
                    end else begin
                        r_d.st = ST_RD_DATA;
                    end
                end
            end
            ST_RD_APP: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.cur + AW'(OFS_APP) + (AW'(r_q.idx) << 2);
                if (mem_ack_i) begin
                    r_d.word = mem_rdata_i;
                    r_d.st   = ST_SEND_APP;
                end
            end
            ST_SEND_APP: begin
                ctl_tvalid_o = 1'b1;
                if (ctl_tready_i) begin
                    if (r_q.idx == IDX_LAST) begin
                        r_d.st = (r_q.left == '0) ? ST_WR_STAT : ST_RD_DATA;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = ST_RD_APP;
                    end
                end
            end
            ST_RD_DATA: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.bptr;
                if (mem_ack_i) begin
                    r_d.word = mem_rdata_i;
                    r_d.st   = ST_SEND_DATA;
                end
            end
            ST_SEND_DATA: begin
                dat_tvalid_o = 1'b1;
                if (dat_tready_i) begin
                    if (last_beat) begin
                        r_d.left = '0;
                        r_d.st   = ST_WR_STAT;
                    end else begin
                        r_d.left = r_q.left - LEN_W'(KEEP_W);
                        r_d.bptr = r_q.bptr + AW'(KEEP_W);
                        r_d.st   = ST_RD_DATA;
                    end
                end
            end
            ST_WR_STAT: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.cur + AW'(OFS_STAT);
                mem_wdata_o = WORD_W'(r_q.len);
                mem_wdata_o[BIT_DONE] = 1'b1;
                if (mem_ack_i) begin
                    r_d.done = r_q.eof;
                    r_d.cur  = r_q.link;
                    if (r_q.cur == r_q.tail) begin
                        set_idle = 1'b1;
                        r_d.st   = ST_WAIT;
                    end else begin
                        r_d.st = ST_RD_LINK;
                    end
                end
            end
            default: r_d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_WAIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl_tdata_o = r_q.word;
    assign ctl_tlast_o = (r_q.idx == IDX_LAST);
    assign dat_tdata_o = r_q.word;
    assign dat_tkeep_o = keep;
    assign dat_tlast_o = r_q.eof && last_beat;
    assign done_o      = r_q.done;

    AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dat_tvalid_o && !dat_tready_i |=> dat_tvalid_o && $stable(dat_tdata_o) && $stable(dat_tkeep_o)); // R12
    AST_NO_REQ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        dat_tvalid_o |-> !mem_req_o); // R12
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_tvalid_o && !ctl_tready_i |=> ctl_tvalid_o && $stable(ctl_tdata_o)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !dat_tvalid_o && !ctl_tvalid_o && !mem_req_o); // R5
    AST_KEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        dat_tvalid_o |-> dat_tkeep_o[0]); // R7
endmodule

// File: tb/sim_sgw_walker.sv
module sim_sgw_walker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        run_i = 0, cur_wr_i = 0, tail_wr_i = 0;
    logic [31:0] cur_addr_i = 0, tail_addr_i = 0;
    logic        mem_req_o, mem_we_o, mem_ack_i;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        ctl_tvalid_o, ctl_tready_i, ctl_tlast_o;
    logic [31:0] ctl_tdata_o;
    logic        dat_tvalid_o, dat_tready_i, dat_tlast_o;
    logic [31:0] dat_tdata_o;
    logic [3:0]  dat_tkeep_o;
    logic        halted_o, idle_o, done_o;

    sgw_walker u0 (.*);

    int checks = 0, failures = 0, cyc = 0;
    logic [31:0] mem [0:255];
    logic ack_q = 0;
    logic [31:0] rd_q = 0;
    logic bp_mode = 0;
    assign mem_ack_i = ack_q;
    assign mem_rdata_i = rd_q;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req_o && !ack_q) begin
            ack_q <= 1'b1;
            rd_q  <= mem[mem_addr_o[9:2]];
            if (mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
        end else begin
            ack_q <= 1'b0;
        end
        dat_tready_i <= bp_mode ? ((cyc % 3) != 0) : 1'b1;
        ctl_tready_i <= bp_mode ? ((cyc % 4) != 1) : 1'b1;
    end

    logic [31:0] bd [0:63];
    logic [3:0]  bk [0:63];
    logic        bl [0:63];
    logic [31:0] cd [0:63];
    logic        cl [0:63];
    int nb = 0, nc = 0, ndone = 0, nreq = 0, viol = 0;
    int wr_ack_cyc = 0, done_cyc = 0, idle_cyc = 0;
    logic stall_p = 0, idle_p = 0;
    logic [31:0] data_p = 0;

    always @(negedge clk) begin
        if (dat_tvalid_o && dat_tready_i && nb < 64) begin
            bd[nb] = dat_tdata_o; bk[nb] = dat_tkeep_o; bl[nb] = dat_tlast_o; nb++;
        end
        if (ctl_tvalid_o && ctl_tready_i && nc < 64) begin
            cd[nc] = ctl_tdata_o; cl[nc] = ctl_tlast_o; nc++;
        end
        if (stall_p && (!dat_tvalid_o || dat_tdata_o != data_p)) viol++;
        if (dat_tvalid_o && mem_req_o) viol++;
        stall_p = dat_tvalid_o && !dat_tready_i;
        data_p  = dat_tdata_o;
        if (done_o) begin ndone++; done_cyc = cyc; end
        if (mem_req_o) nreq++;
        if (mem_req_o && mem_we_o && mem_ack_i) wr_ack_cyc = cyc;
        if (idle_o && !idle_p) idle_cyc = cyc;
        idle_p = idle_o;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_desc(int base, int link, int bufa, logic [31:0] ctrl,
                            logic [31:0] stat, logic [31:0] appv);
        mem[base/4 + 0] = link;  mem[base/4 + 1] = 0;
        mem[base/4 + 2] = bufa;  mem[base/4 + 3] = 0;
        mem[base/4 + 6] = ctrl;  mem[base/4 + 7] = stat;
        for (int k = 0; k < 5; k++) mem[base/4 + 8 + k] = appv + k;
    endtask

    task automatic pulse_cur(int a);
        @(negedge clk); cur_wr_i = 1; cur_addr_i = a;
        @(negedge clk); cur_wr_i = 0;
    endtask

    task automatic pulse_tail(int a);
        @(negedge clk); tail_wr_i = 1; tail_addr_i = a;
        @(negedge clk); tail_wr_i = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
        for (int i = 0; i < 3000 && !(idle_o || halted_o); i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    localparam logic [31:0] SOF = 32'h0800_0000, EOF = 32'h0400_0000;

    task automatic t_reset();
        chk("R1 halted", halted_o, 1);
        chk("R1 idle", idle_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 req", mem_req_o, 0);
        chk("R1 valid", {dat_tvalid_o, ctl_tvalid_o}, 0);
    endtask

    task automatic t_single();
        pulse_cur('h000);
        pulse_tail('h000);
        repeat (10) @(negedge clk);
        chk("R2 no walk before run", nreq, 0);
        run_i = 1;
        settle();
        chk("R6 ctl count", nc, 5);
        for (int k = 0; k < 5; k++) chk("R6 ctl word", cd[k], 32'hA0 + k);
        chk("R6 ctl last", {cl[0], cl[1], cl[2], cl[3], cl[4]}, 5'b00001);
        chk("R3 R7 beat count", nb, 3);
        for (int k = 0; k < 3; k++) chk("R3 R7 beat data", bd[k], mem['h200/4 + k]);
        chk("R7 keeps", {bk[0], bk[1], bk[2]}, 12'hFF3);
        chk("R8 last", {bl[0], bl[1], bl[2]}, 3'b001);
        chk("R9 status", mem[7], 32'h8000_000A);
        chk("R10 done count", ndone, 1);
        chk("R10 done timing", done_cyc, wr_ack_cyc + 1);
        chk("R11 idle", idle_o, 1);
        chk("R11 idle timing", idle_cyc, wr_ack_cyc + 1);
        chk("R11 next untouched", mem['h040/4 + 7], 0);
        chk("R2 halted clear", halted_o, 0);
    endtask

    task automatic t_chain();
        nb = 0; nc = 0;
        bp_mode = 1;
        pulse_tail('h0C0);
        settle();
        chk("R11 resumed beats", nb, 5);
        chk("R7 keeps", {bk[0], bk[1], bk[2], bk[3], bk[4]}, 20'hFFFF1);
        chk("R8 lasts", {bl[0], bl[1], bl[2], bl[3], bl[4]}, 5'b10001);
        chk("R7 data", bd[4], mem['h2C0/4 + 1]);
        chk("R6 one header", nc, 5);
        chk("R6 header word", cd[0], 32'hC0);
        chk("R9 B status", mem['h040/4 + 7], 32'h8000_0004);
        chk("R9 C status", mem['h080/4 + 7], 32'h8000_0008);
        chk("R9 D status", mem['h0C0/4 + 7], 32'h8000_0005);
        chk("R10 frame dones", ndone, 3);
        chk("R12 stall violations", viol, 0);
        chk("R4 R11 idle", idle_o, 1);
        bp_mode = 0;
    endtask

    task automatic t_halt();
        int r0;
        nb = 0; nc = 0;
        pulse_tail('h100);
        settle();
        chk("R5 halted", halted_o, 1);
        chk("R5 no beats", nb + nc, 0);
        chk("R5 status untouched", mem['h100/4 + 7], 32'h8000_0123);
        chk("R5 no done", ndone, 3);
        r0 = nreq;
        pulse_tail('h100);
        repeat (20) @(negedge clk);
        chk("R2 halted tail write", nreq, r0);
    endtask

    task automatic t_zero();
        nb = 0;
        pulse_cur('h140);
        pulse_tail('h140);
        @(negedge clk); run_i = 0;
        @(negedge clk); run_i = 1;
        settle();
        chk("R2 run rise clears halt", halted_o, 0);
        chk("R13 no beats", nb, 0);
        chk("R13 status", mem['h140/4 + 7], 32'h8000_0000);
        chk("R10 zero done", ndone, 4);
        chk("R11 zero idle", idle_o, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hB000_0000 + i;
        put_desc('h000, 'h040, 'h200, SOF | EOF | 10, 0, 32'hA0);
        put_desc('h040, 'h080, 'h240, EOF | 4, 0, 32'hB0);
        put_desc('h080, 'h0C0, 'h280, SOF | 8, 0, 32'hC0);
        put_desc('h0C0, 'h100, 'h2C0, EOF | 5, 0, 32'hD0);
        put_desc('h100, 'h180, 'h300, SOF | EOF | 4, 32'h8000_0123, 32'hE0);
        put_desc('h140, 'h180, 'h300, EOF, 0, 32'hF0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_halt();
        t_zero();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule